// File: doc/BRIEF.md
# Binary/Decimal Byte ALU

This block is the arithmetic and logic unit of a small 8-bit processor. Each operation takes the value of a working register, an operand byte, and the current carry, decimal and overflow flags. It returns a result byte, new negative, zero, carry and overflow flags, a mask that says which of those flags the operation defines, and a bit that says whether the result is meant to be written back. The register file, the operand fetch and the instruction sequencing sit outside the block. The caller only drives an operation code with a one-cycle strobe and takes the registered outputs one clock later.

Add and subtract have a decimal variant, which is selected by the decimal flag input. In that variant each 4-bit digit is corrected to packed BCD. The negative, zero and overflow flags still follow the plain binary sum, as the older NMOS parts did. Compare and bit test change only flags. Increment and decrement change only negative and zero. A flag that an operation does not define leaves the block equal to its incoming value, so the flag outputs always form a complete new flag state.

Top module: `alu8_core`

## Requirements
- R1: Op 0 (add with carry), decimal input low: result = (reg_a + opnd_b + c_in) mod 256, C = bit 8 of that sum, V = 1 when both inputs share a sign bit that the result does not have, N = result bit 7, Z = (result == 0).
- R2: Op 0 with d_in high: the low digit is the low digits plus c_in, and it gets +6 with a carry into the high digit when above 9. The high digit is the high digits plus that carry, and it gets +6 when above 9. C is bit 4 of the adjusted high digit (so 0xF0 + 0xF0 gives 0x40 with C = 0).
- R3: For decimal add and subtract, N, Z and V are computed from the binary result, not the corrected one (0x99 + 0x66 + 1 gives 0x66 with Z = 1).
- R4: Op 1 (subtract with borrow), decimal input low: result = reg_a - opnd_b - (1 - c_in) mod 256, C = 1 when no borrow occurred, V = 1 when the input signs differ and the result sign differs from reg_a, N and Z from the result.
- R5: Op 1 with d_in high: a digit whose difference goes negative has 6 subtracted, and a low-digit borrow takes one from the high digit. C is still the binary no-borrow (0x00 - 0x01 - 1 gives 0x98, C = 0).
- R6: Ops 2, 3 and 4 give AND, OR and XOR of reg_a and opnd_b, with N and Z from the result.
- R7: Op 5 (compare): C = (reg_a >= opnd_b) unsigned, N and Z from (reg_a - opnd_b) mod 256, no decimal correction, res_q = reg_a and res_wr_q = 0.
- R8: Op 6 (bit test): N = opnd_b bit 7, V = opnd_b bit 6, Z = ((reg_a & opnd_b) == 0), res_q = reg_a and res_wr_q = 0.
- R9: Ops 7 to 10 act on reg_a. Shift left puts bit 7 into C and fills with 0. Shift right puts bit 0 into C and fills with 0. Rotate left and rotate right fill the vacated bit with c_in. N and Z come from the result.
- R10: Op 11 adds 1 to reg_a and op 12 subtracts 1 from it, modulo 256, with only N and Z defined. The decimal input has no effect on these ops.
- R11: flg_upd_q bit 3 is N, bit 2 Z, bit 1 C and bit 0 V, and a bit is set when the last operation defined that flag. A flag whose bit is clear is output equal to its incoming c_in or v_in value.
- R12: All outputs load at the rising edge where in_vld is high, and they hold their values in every cycle in which in_vld is low.
- R13: Op codes 13, 14 and 15 are reserved, and a strobe carrying one of them leaves every output unchanged.
- R14: Synchronous active-low reset clears res_q, res_wr_q, all four flags and flg_upd_q to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code |
| reg_a | input | W (8) | Working register value |
| opnd_b | input | W (8) | Operand byte |
| c_in | input | 1 | Current carry flag |
| d_in | input | 1 | Current decimal flag |
| v_in | input | 1 | Current overflow flag |
| res_q | output | W (8) | Registered result |
| res_wr_q | output | 1 | Result is meant for write-back |
| flg_n_q | output | 1 | Negative flag |
| flg_z_q | output | 1 | Zero flag |
| flg_c_q | output | 1 | Carry flag |
| flg_v_q | output | 1 | Overflow flag |
| flg_upd_q | output | 4 | Flags defined by the last operation (N,Z,C,V) |

## Verification
The bench targets the digit corrections. A decimal add that carries out of 99 must wrap to 00 with C set, and a decimal subtract that borrows through both digits must give 98. The add that overflows the high digit twice must leave C clear; a design that takes the carry from a "greater than 9" test would set it there. The binary-flag quirk is checked with a sum whose corrected value is non-zero while its binary value is zero. A design that takes Z or N from the corrected value reports Z = 0 on that case. Compare with the decimal flag set, increment with the decimal flag set, and the reserved codes and idle cycles are all checked as well. A design that lets the decimal flag leak into those ops, or that writes on a strobe it should ignore, would change the result or the pass-through carry and overflow values.

// File: rtl/alu8_pkg.sv
// Shared types for the byte ALU: operation codes and flag-mask constants.
// Assumes a 4-bit operation code; values 13..15 are reserved.
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_CMP  = 4'd5,
        OP_BTST = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_ROTL = 4'd9,
        OP_ROTR = 4'd10,
        OP_INC  = 4'd11,
        OP_DEC  = 4'd12
    } alu_op_e;

    // flag mask order: N, Z, C, V (bit 3 down to bit 0)
    localparam logic [3:0] MSK_NZCV = 4'b1111;
    localparam logic [3:0] MSK_NZC  = 4'b1110;
    localparam logic [3:0] MSK_NZV  = 4'b1101;
    localparam logic [3:0] MSK_NZ   = 4'b1100;

endpackage

// File: rtl/alu8_arith.sv
// Adder/subtractor with optional per-digit BCD correction.
// Assumes W is a multiple of 4. Subtract uses the carry as an inverted borrow.
// The binary result is always provided, because the N, Z and V flags follow it.
module alu8_arith #(
    parameter int W      = 8,
    parameter bit DEC_EN = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         dec,
    output logic [W-1:0] res,
    output logic [W-1:0] bin_res,
    output logic         cout,
    output logic         vout
);
    localparam int NIB = W / 4;

    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic [W-1:0] dres;
    logic         dcarry;
    logic [5:0]   nib;
    logic [3:0]   an, bn;
    logic         k;

    // binary path: subtract as a + ~b + cin
    always_comb begin
        b_eff   = sub ? ~b : b;
        sum     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        bin_res = sum[W-1:0];
        vout    = ~(a[W-1] ^ b_eff[W-1]) & (a[W-1] ^ sum[W-1]);
    end

    // decimal path: digit chain from least significant upwards
    always_comb begin
        k      = sub ? ~cin : cin;
        dres   = '0;
        nib    = '0;
        an     = '0;
        bn     = '0;
        for (int i = 0; i < NIB; i++) begin
            an = a[4*i +: 4];
            bn = b[4*i +: 4];
            if (sub) begin
                nib = {2'b00, an} - {2'b00, bn} - {5'b0, k};
                if (nib[4]) begin
                    nib = nib - 6'd6;
                    k   = 1'b1;
                end else begin
                    k   = 1'b0;
                end
            end else begin
                nib = {2'b00, an} + {2'b00, bn} + {5'b0, k};
                if (nib > 6'd9) begin
                    nib = nib + 6'd6;
                    k   = (i == NIB - 1) ? nib[4] : 1'b1;
                end else begin
                    k   = 1'b0;
                end
            end
            dres[4*i +: 4] = nib[3:0];
        end
        dcarry = k;
    end

    // pick the variant the parameter asks for
    generate
        if (DEC_EN) begin : g_dec
            assign res  = dec ? dres : sum[W-1:0];
            assign cout = (dec && !sub) ? dcarry : sum[W];
        end else begin : g_bin
            assign res  = sum[W-1:0];
            assign cout = sum[W];
        end
    endgenerate

endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit: AND, OR, XOR of two bytes. Other op codes return a.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    // select the bitwise function
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
// Shift, rotate and step unit acting on one byte.
// Rotates take the incoming carry. Increment and decrement return cin as carry.
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    // one-position moves and +/-1 steps
    always_comb begin
        res  = a;
        cout = cin;
        case (op)
            OP_SHL:  begin res = {a[W-2:0], 1'b0}; cout = a[W-1]; end
            OP_SHR:  begin res = {1'b0, a[W-1:1]}; cout = a[0];   end
            OP_ROTL: begin res = {a[W-2:0], cin};  cout = a[W-1]; end
            OP_ROTR: begin res = {cin, a[W-1:1]};  cout = a[0];   end
            OP_INC:  res = a + {{(W-1){1'b0}}, 1'b1};
            OP_DEC:  res = a - {{(W-1){1'b0}}, 1'b1};
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
// Top of the byte ALU. Decodes the operation, steers the three units and
// registers the result, the flags, the flag-defined mask and the write-back bit.
// Assumes the caller merges the flag outputs into its status register.
// Flags an op does not define are passed through from c_in and v_in.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] opnd_b,
    input  logic         c_in,
    input  logic         d_in,
    input  logic         v_in,
    output logic [W-1:0] res_q,
    output logic         res_wr_q,
    output logic         flg_n_q,
    output logic         flg_z_q,
    output logic         flg_c_q,
    output logic         flg_v_q,
    output logic [3:0]   flg_upd_q
);
    alu_op_e      op;
    logic         ar_sub, ar_cin, ar_dec, ar_c, ar_v;
    logic [W-1:0] ar_res, ar_bin, lg_res, sh_res;
    logic         sh_c;
    logic [W-1:0] nxt_res;
    logic         nxt_wr, legal, n_new, z_new, c_new, v_new;
    logic [3:0]   nxt_msk;

    assign op = alu_op_e'(op_sel);

    // compare reuses the subtractor with no borrow and no decimal mode
    always_comb begin
        ar_sub = (op == OP_SUB) || (op == OP_CMP);
        ar_cin = (op == OP_CMP) ? 1'b1 : c_in;
        ar_dec = d_in && ((op == OP_ADD) || (op == OP_SUB));
    end

    alu8_arith #(.W(W), .DEC_EN(1'b1)) u_arith (
        .a(reg_a), .b(opnd_b), .cin(ar_cin), .sub(ar_sub), .dec(ar_dec),
        .res(ar_res), .bin_res(ar_bin), .cout(ar_c), .vout(ar_v)
    );

    alu8_logic #(.W(W)) u_logic (
        .op(op), .a(reg_a), .b(opnd_b), .res(lg_res)
    );

    alu8_shift #(.W(W)) u_shift (
        .op(op), .a(reg_a), .cin(c_in), .res(sh_res), .cout(sh_c)
    );

    // pick result, flags, mask and write-back for the current op
    always_comb begin
        nxt_res = reg_a;
        nxt_wr  = 1'b0;
        nxt_msk = 4'b0000;
        legal   = 1'b1;
        n_new   = 1'b0;
        z_new   = 1'b0;
        c_new   = c_in;
        v_new   = v_in;
        case (op)
            OP_ADD, OP_SUB: begin
                nxt_res = ar_res;
                nxt_wr  = 1'b1;
                nxt_msk = MSK_NZCV;
                n_new   = ar_bin[W-1];
                z_new   = (ar_bin == '0);
                c_new   = ar_c;
                v_new   = ar_v;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_res = lg_res;
                nxt_wr  = 1'b1;
                nxt_msk = MSK_NZ;
                n_new   = lg_res[W-1];
                z_new   = (lg_res == '0);
            end
            OP_CMP: begin
                nxt_msk = MSK_NZC;
                n_new   = ar_bin[W-1];
                z_new   = (ar_bin == '0);
                c_new   = ar_c;
            end
            OP_BTST: begin
                nxt_msk = MSK_NZV;
                n_new   = opnd_b[W-1];
                z_new   = ((reg_a & opnd_b) == '0);
                v_new   = opnd_b[W-2];
            end
            OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
                nxt_res = sh_res;
                nxt_wr  = 1'b1;
                nxt_msk = MSK_NZC;
                n_new   = sh_res[W-1];
                z_new   = (sh_res == '0);
                c_new   = sh_c;
            end
            OP_INC, OP_DEC: begin
                nxt_res = sh_res;
                nxt_wr  = 1'b1;
                nxt_msk = MSK_NZ;
                n_new   = sh_res[W-1];
                z_new   = (sh_res == '0);
            end
            default: legal = 1'b0;
        endcase
    end

    // output registers: load on a legal strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_wr_q  <= 1'b0;
            flg_n_q   <= 1'b0;
            flg_z_q   <= 1'b0;
            flg_c_q   <= 1'b0;
            flg_v_q   <= 1'b0;
            flg_upd_q <= 4'b0000;
        end else if (in_vld && legal) begin
            res_q     <= nxt_res;
            res_wr_q  <= nxt_wr;
            flg_n_q   <= n_new;
            flg_z_q   <= z_new;
            flg_c_q   <= c_new;
            flg_v_q   <= v_new;
            flg_upd_q <= nxt_msk;
        end
    end

endmodule

// File: rtl/alu8_core_chk.sv
// Property checker for alu8_core, attached with bind. Observes ports only.
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_vld,
    input logic [3:0]   op_sel,
    input logic [W-1:0] reg_a,
    input logic [W-1:0] opnd_b,
    input logic         c_in,
    input logic         v_in,
    input logic [W-1:0] res_q,
    input logic         res_wr_q,
    input logic         flg_n_q,
    input logic         flg_c_q,
    input logic         flg_v_q,
    input logic [3:0]   flg_upd_q
);
    // R12: idle cycles leave every output alone
    a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(res_q) && $stable(res_wr_q) && $stable(flg_upd_q)
                     && $stable(flg_c_q) && $stable(flg_v_q)));

    // R11: every legal op defines N and Z
    a_r11_nz_always: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_sel <= 4'd12) |=> (flg_upd_q[3] && flg_upd_q[2]));

    // R7: compare keeps the register and does not request write-back
    a_r7_cmp_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_sel == 4'd5) |=> (!res_wr_q && res_q == $past(reg_a)
                                        && flg_v_q == $past(v_in)));

    // R8: bit test copies operand bits 7 and 6
    a_r8_bit_nv: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_sel == 4'd6) |=> (flg_n_q == $past(opnd_b[W-1])
                                        && flg_v_q == $past(opnd_b[W-2])
                                        && flg_c_q == $past(c_in)));

    // R9: shift left moves the top bit into carry
    a_r9_shl_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_sel == 4'd7) |=> (flg_c_q == $past(reg_a[W-1])));

    // R10: increment and decrement pass carry and overflow through
    a_r10_incdec_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (op_sel == 4'd11 || op_sel == 4'd12)) |=>
        (flg_c_q == $past(c_in) && flg_v_q == $past(v_in) && flg_upd_q[1:0] == 2'b00));

    // R13: a reserved code changes nothing
    a_r13_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_sel > 4'd12) |=> ($stable(res_q) && $stable(flg_upd_q)));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_sel(op_sel),
    .reg_a(reg_a), .opnd_b(opnd_b), .c_in(c_in), .v_in(v_in),
    .res_q(res_q), .res_wr_q(res_wr_q), .flg_n_q(flg_n_q),
    .flg_c_q(flg_c_q), .flg_v_q(flg_v_q), .flg_upd_q(flg_upd_q)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
// Directed bench for alu8_core: one task per scenario, each checking its results.
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] reg_a = '0, opnd_b = '0;
    logic       c_in = 1'b0, d_in = 1'b0, v_in = 1'b0;
    logic [7:0] res_q;
    logic       res_wr_q, flg_n_q, flg_z_q, flg_c_q, flg_v_q;
    logic [3:0] flg_upd_q;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu8_core #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_sel(op_sel),
        .reg_a(reg_a), .opnd_b(opnd_b), .c_in(c_in), .d_in(d_in), .v_in(v_in),
        .res_q(res_q), .res_wr_q(res_wr_q), .flg_n_q(flg_n_q), .flg_z_q(flg_z_q),
        .flg_c_q(flg_c_q), .flg_v_q(flg_v_q), .flg_upd_q(flg_upd_q)
    );

    // compare all outputs; flags given as {N,Z,C,V}
    task automatic chk(input string tag, input logic [7:0] er, input logic [3:0] ef,
                       input logic [3:0] em, input logic ew);
        logic [16:0] got, exp;
        got = {res_q, flg_n_q, flg_z_q, flg_c_q, flg_v_q, flg_upd_q, res_wr_q};
        exp = {er, ef, em, ew};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got res=%h nzcv=%b upd=%b wr=%b, expected res=%h nzcv=%b upd=%b wr=%b",
                     tag, got[16:9], got[8:5], got[4:1], got[0], er, ef, em, ew);
        end
    endtask

    // one strobe; outputs are sampled one cycle later, away from the edge
    task automatic run(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic d, input logic v);
        @(negedge clk);
        op_sel = op; reg_a = a; opnd_b = b; c_in = c; d_in = d; v_in = v;
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic t_reset;
        chk("R14 reset state", 8'h00, 4'b0000, 4'b0000, 1'b0);
    endtask

    task automatic t_add_bin;
        run(4'd0, 8'h50, 8'h50, 0, 0, 0); chk("R1 add 50+50", 8'hA0, 4'b1001, 4'b1111, 1);
        run(4'd0, 8'hFF, 8'h01, 0, 0, 1); chk("R1 add FF+01", 8'h00, 4'b0110, 4'b1111, 1);
        run(4'd0, 8'h7F, 8'h00, 1, 0, 0); chk("R1 add 7F+00+c", 8'h80, 4'b1001, 4'b1111, 1);
    endtask

    task automatic t_add_dec;
        run(4'd0, 8'h12, 8'h34, 0, 1, 0); chk("R2 dec 12+34", 8'h46, 4'b0000, 4'b1111, 1);
        run(4'd0, 8'h99, 8'h01, 0, 1, 0); chk("R2 dec 99+01", 8'h00, 4'b1010, 4'b1111, 1);
        run(4'd0, 8'hF0, 8'hF0, 0, 1, 0); chk("R2 dec F0+F0 carry bit4", 8'h40, 4'b1000, 4'b1111, 1);
    endtask

    task automatic t_dec_flags;
        run(4'd0, 8'h58, 8'h46, 1, 1, 0); chk("R3 dec 58+46+1 V binary", 8'h05, 4'b1011, 4'b1111, 1);
        run(4'd0, 8'h99, 8'h66, 1, 1, 0); chk("R3 dec 99+66+1 Z binary", 8'h66, 4'b0110, 4'b1111, 1);
    endtask

    task automatic t_sub_bin;
        run(4'd1, 8'h50, 8'h30, 1, 0, 0); chk("R4 sub 50-30", 8'h20, 4'b0010, 4'b1111, 1);
        run(4'd1, 8'h30, 8'h50, 1, 0, 0); chk("R4 sub 30-50", 8'hE0, 4'b1000, 4'b1111, 1);
        run(4'd1, 8'h80, 8'h01, 1, 0, 0); chk("R4 sub 80-01 V", 8'h7F, 4'b0011, 4'b1111, 1);
        run(4'd1, 8'h05, 8'h05, 0, 0, 0); chk("R4 sub 05-05-borrow", 8'hFF, 4'b1000, 4'b1111, 1);
    endtask

    task automatic t_sub_dec;
        run(4'd1, 8'h50, 8'h01, 1, 1, 0); chk("R5 dec 50-01", 8'h49, 4'b0010, 4'b1111, 1);
        run(4'd1, 8'h10, 8'h20, 1, 1, 0); chk("R5 dec 10-20", 8'h90, 4'b1000, 4'b1111, 1);
        run(4'd1, 8'h00, 8'h01, 0, 1, 0); chk("R5 dec 00-01-borrow", 8'h98, 4'b1000, 4'b1111, 1);
    endtask

    task automatic t_logic;
        run(4'd2, 8'hF0, 8'h0F, 1, 0, 1); chk("R6 and", 8'h00, 4'b0111, 4'b1100, 1);
        run(4'd3, 8'h80, 8'h01, 0, 0, 0); chk("R6 or", 8'h81, 4'b1000, 4'b1100, 1);
        run(4'd4, 8'hFF, 8'h0F, 1, 0, 0); chk("R6 xor", 8'hF0, 4'b1010, 4'b1100, 1);
    endtask

    task automatic t_cmp;
        run(4'd5, 8'h40, 8'h40, 0, 0, 1); chk("R7 cmp equal", 8'h40, 4'b0111, 4'b1110, 0);
        run(4'd5, 8'h10, 8'h20, 1, 0, 0); chk("R7 cmp less", 8'h10, 4'b1000, 4'b1110, 0);
        run(4'd5, 8'h05, 8'hFF, 1, 0, 0); chk("R7 cmp unsigned", 8'h05, 4'b0000, 4'b1110, 0);
        run(4'd5, 8'h10, 8'h01, 0, 1, 0); chk("R7 cmp ignores decimal", 8'h10, 4'b0010, 4'b1110, 0);
    endtask

    task automatic t_bit;
        run(4'd6, 8'h0F, 8'hC0, 1, 0, 0); chk("R8 bit test zero", 8'h0F, 4'b1111, 4'b1101, 0);
        run(4'd6, 8'h01, 8'h01, 0, 0, 1); chk("R8 bit test nonzero", 8'h01, 4'b0000, 4'b1101, 0);
    endtask

    task automatic t_shift;
        run(4'd7,  8'h81, 8'h00, 0, 0, 0); chk("R9 shl", 8'h02, 4'b0010, 4'b1110, 1);
        run(4'd8,  8'h01, 8'h00, 1, 0, 1); chk("R9 shr", 8'h00, 4'b0111, 4'b1110, 1);
        run(4'd9,  8'h80, 8'h00, 1, 0, 0); chk("R9 rotl", 8'h01, 4'b0010, 4'b1110, 1);
        run(4'd10, 8'h01, 8'h00, 1, 0, 0); chk("R9 rotr carry in", 8'h80, 4'b1010, 4'b1110, 1);
        run(4'd10, 8'h02, 8'h00, 0, 0, 0); chk("R9 rotr zero in", 8'h01, 4'b0000, 4'b1110, 1);
    endtask

    task automatic t_incdec;
        run(4'd11, 8'hFF, 8'h00, 1, 1, 1); chk("R10 inc wrap, R11 pass C V", 8'h00, 4'b0111, 4'b1100, 1);
        run(4'd12, 8'h00, 8'h00, 0, 0, 0); chk("R10 dec wrap", 8'hFF, 4'b1000, 4'b1100, 1);
        run(4'd11, 8'h09, 8'h00, 0, 1, 0); chk("R10 inc ignores decimal", 8'h0A, 4'b0000, 4'b1100, 1);
    endtask

    task automatic t_hold;
        @(negedge clk);
        op_sel = 4'd0; reg_a = 8'h33; opnd_b = 8'h44; c_in = 1; d_in = 0; v_in = 1;
        repeat (3) @(negedge clk);
        chk("R12 idle inputs ignored", 8'h0A, 4'b0000, 4'b1100, 1);
    endtask

    task automatic t_reserved;
        for (int code = 13; code < 16; code++) begin
            run(code[3:0], 8'h77, 8'h11, 1, 0, 1);
            chk("R13 reserved code", 8'h0A, 4'b0000, 4'b1100, 1);
        end
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_add_bin;
        t_add_dec;
        t_dec_flags;
        t_sub_bin;
        t_sub_dec;
        t_logic;
        t_cmp;
        t_bit;
        t_shift;
        t_incdec;
        t_hold;
        t_reserved;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule